// File: doc/BRIEF.md
# Dual-Mode Startup Watchdog Timer

This block watches a heartbeat line driven by a processor and asks the reset sequencer for a system reset when the heartbeat stops changing level. After every reset the timer runs a long startup window. This gives the software time to boot before it has to service the watchdog. The first accepted heartbeat change moves the timer to a short normal window. From then on, every accepted change restarts the count. A rising change and a falling change both count as service.

The heartbeat passes through a two-flop synchronizer and then a stability filter. A new level counts as a transition only after it has held for a set number of clock cycles. On expiry the block emits a single-cycle pulse and then stays silent until the system reset has been asserted and released. An enable input stands in for the disabled (unconnected heartbeat) case. While it is low the count is held at zero and no expiry can occur. Both window lengths and the filter length are cycle-count parameters: `LONG_TICKS`, `SHORT_TICKS` and `STABLE_CYCLES`.

Top module: `startup_watchdog`

## Requirements
- R1: After `sys_rst` is released with no accepted heartbeat change, `wdt_expire` first goes high in the `LONG_TICKS`-th clock cycle after release. "Released" means that the first rising edge with `sys_rst` low counts as cycle 1.
- R2: The first accepted heartbeat change after reset switches the block to the short window. A change driven on `hb_in` before rising edge k restarts the count at edge k+`STABLE_CYCLES`+2. `wdt_expire` then pulses after a total of `STABLE_CYCLES`+3+`SHORT_TICKS` cycles from the change.
- R3: A falling heartbeat change and a rising heartbeat change both service the watchdog. Each one restarts the short window with the same latency as in R2.
- R4: While `sys_rst` is high the count is held at zero and `wdt_expire` stays low, however long reset lasts and whatever `hb_in` does.
- R5: After an expiry, a new reset puts the block back in the long startup window. The next expiry is again `LONG_TICKS` cycles after release.
- R6: `wdt_expire` is high for exactly one cycle per expiry. No further pulse occurs until `sys_rst` has been asserted and released.
- R7: A level on `hb_in` that lasts fewer than `STABLE_CYCLES` cycles after synchronization is ignored. It does not switch the mode and does not restart the count. A level that lasts exactly `STABLE_CYCLES` cycles is accepted.
- R8: While `wd_en` is low, `wdt_expire` stays low, the count is held at zero and heartbeat changes have no effect on the mode. Once `wd_en` is raised, a full window of the current mode starts at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one tick per cycle |
| sys_rst | input | 1 | System reset state, active high, synchronous |
| hb_in | input | 1 | Asynchronous heartbeat from the processor |
| wd_en | input | 1 | Watchdog enable; low means the watchdog is disabled |
| wdt_expire | output | 1 | One-cycle expiry request to the reset sequencer |

## Verification
Every result is tied to a cycle number. The long expiry is due `LONG_TICKS` cycles after reset release. An expiry after service is due `STABLE_CYCLES`+3+`SHORT_TICKS` cycles after the heartbeat change: two synchronizer stages, the filter run, one registered event and the window itself. The bench drives inputs on falling edges and samples on falling edges. It counts cycles from the stimulus and records the cycle of the first pulse and the number of pulses in the window. It then compares both against the arithmetic figure. This makes an early or late expiry by even one cycle visible. A sweep moves the first heartbeat change across every cycle of the startup window where it can land in time. Glitch tests use a pulse one cycle shorter than the filter length and a pulse of exactly that length.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    // Operating mode of the watchdog timer
    typedef enum logic [1:0] {
        WD_BOOT  = 2'd0,   // long startup window
        WD_RUN   = 2'd1,   // short normal window
        WD_SPENT = 2'd2    // expired, waiting for reset
    } wd_mode_e;

    // Filtered heartbeat event
    typedef struct packed {
        logic level;    // accepted heartbeat level
        logic toggled;  // one-cycle strobe on an accepted change
    } hb_evt_t;

    // Bits needed to hold values 0 .. n-1
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wdg_sync.sv
module wdg_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) chain[0] <= async_in;
            end else begin : g_next
                always_ff @(posedge clk) chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/wdg_filter.sv
module wdg_filter
    import wdg_pkg::*;
#(
    parameter int unsigned STABLE_CYCLES = 3
) (
    input  logic    clk,
    input  logic    sys_rst,
    input  logic    hb_sync,
    output hb_evt_t evt
);
    localparam int unsigned RW = cnt_width(STABLE_CYCLES + 1);
    localparam logic [RW-1:0] RUN_LAST = RW'(STABLE_CYCLES - 1);

    logic [RW-1:0] run_q;
    logic          level_q;
    logic          tog_q;

    always_ff @(posedge clk) begin
        if (sys_rst) begin
            level_q <= hb_sync;     // track the line so release gives no false change
            run_q   <= '0;
            tog_q   <= 1'b0;
        end else begin
            tog_q <= 1'b0;
            if (hb_sync == level_q) begin
                run_q <= '0;
            end else if (run_q == RUN_LAST) begin
                level_q <= hb_sync;
                run_q   <= '0;
                tog_q   <= 1'b1;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign evt.level   = level_q;
    assign evt.toggled = tog_q;
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
    import wdg_pkg::*;
#(
    parameter int unsigned LONG_TICKS  = 40,
    parameter int unsigned SHORT_TICKS = 12
) (
    input  logic     clk,
    input  logic     sys_rst,
    input  logic     wd_en,
    input  logic     service,
    output wd_mode_e mode,
    output logic     expire
);
    localparam int unsigned CW = cnt_width(max_u(LONG_TICKS, SHORT_TICKS));
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_TICKS - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_TICKS - 1);

    wd_mode_e      mode_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;
    logic          exp_q;

    always_comb limit = (mode_q == WD_BOOT) ? LONG_LAST : SHORT_LAST;

    always_ff @(posedge clk) begin
        if (sys_rst) begin
            mode_q <= WD_BOOT;
            cnt_q  <= '0;
            exp_q  <= 1'b0;
        end else begin
            exp_q <= 1'b0;
            if (!wd_en) begin
                cnt_q <= '0;
            end else begin
                unique case (mode_q)
                    WD_SPENT: cnt_q <= '0;
                    default: begin
                        if (service) begin
                            cnt_q  <= '0;
                            mode_q <= WD_RUN;
                        end else if (cnt_q == limit) begin
                            cnt_q  <= '0;
                            exp_q  <= 1'b1;
                            mode_q <= WD_SPENT;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    assign mode   = mode_q;
    assign expire = exp_q;
endmodule

// File: rtl/startup_watchdog.sv
module startup_watchdog
    import wdg_pkg::*;
#(
    parameter int unsigned LONG_TICKS    = 54_000_000,
    parameter int unsigned SHORT_TICKS   = 1_680_000,
    parameter int unsigned STABLE_CYCLES = 13
) (
    input  logic clk,
    input  logic sys_rst,
    input  logic hb_in,
    input  logic wd_en,
    output logic wdt_expire
);
    logic     hb_sync;
    hb_evt_t  hb_evt;
    logic     hb_toggled;
    wd_mode_e cur_mode;

    wdg_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .async_in (hb_in),
        .sync_out (hb_sync)
    );

    wdg_filter #(.STABLE_CYCLES(STABLE_CYCLES)) u_filter (
        .clk     (clk),
        .sys_rst (sys_rst),
        .hb_sync (hb_sync),
        .evt     (hb_evt)
    );

    assign hb_toggled = hb_evt.toggled;

    wdg_timer #(
        .LONG_TICKS  (LONG_TICKS),
        .SHORT_TICKS (SHORT_TICKS)
    ) u_timer (
        .clk     (clk),
        .sys_rst (sys_rst),
        .wd_en   (wd_en),
        .service (hb_toggled),
        .mode    (cur_mode),
        .expire  (wdt_expire)
    );
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker (
    input logic clk,
    input logic sys_rst,
    input logic wd_en,
    input logic expire,
    input logic edge_ok
);
    logic fired_q;

    always_ff @(posedge clk) begin
        if (sys_rst) fired_q <= 1'b0;
        else if (expire) fired_q <= 1'b1;
    end

    assert_single_cycle_R6: assert property (@(posedge clk) disable iff (sys_rst)
        expire |=> !expire);

    assert_silent_after_fire_R6: assert property (@(posedge clk) disable iff (sys_rst)
        fired_q |-> !expire);

    assert_held_in_reset_R4: assert property (@(posedge clk)
        sys_rst |=> !expire);

    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (sys_rst)
        !wd_en |=> !expire);

    assert_service_clears_R3: assert property (@(posedge clk) disable iff (sys_rst)
        (edge_ok && wd_en) |=> !expire);
endmodule

bind startup_watchdog wdg_checker u_wdg_checker (
    .clk     (clk),
    .sys_rst (sys_rst),
    .wd_en   (wd_en),
    .expire  (wdt_expire),
    .edge_ok (hb_toggled)
);

// File: tb/test_startup_watchdog.sv
`timescale 1ns/1ps
module test_startup_watchdog;
    localparam int L = 40;
    localparam int S = 12;
    localparam int F = 3;
    localparam int D = F + 3 + S;   // heartbeat change to expiry, in cycles

    logic clk = 1'b0;
    logic sys_rst = 1'b1;
    logic hb_in = 1'b0;
    logic wd_en = 1'b1;
    logic wdt_expire;

    int checks = 0;
    int errors = 0;
    int first_hit;
    int hits;
    int acc;

    always #2 clk = ~clk;   // 250 MHz

    startup_watchdog #(
        .LONG_TICKS    (L),
        .SHORT_TICKS   (S),
        .STABLE_CYCLES (F)
    ) i_startup_watchdog (
        .clk        (clk),
        .sys_rst    (sys_rst),
        .hb_in      (hb_in),
        .wd_en      (wd_en),
        .wdt_expire (wdt_expire)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Runs n cycles; records the cycle of the first pulse and the pulse count
    task automatic watch(input int n);
        first_hit = -1;
        hits = 0;
        for (int i = 1; i <= n; i++) begin
            tick();
            if (wdt_expire) begin
                hits++;
                if (first_hit < 0) first_hit = i;
            end
        end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_pulse(input int n, input string req);
        watch(n);
        check(first_hit == n && hits == 1, req, first_hit, n);
    endtask

    task automatic expect_quiet(input int n, input string req);
        watch(n);
        check(hits == 0, req, hits, 0);
    endtask

    task automatic do_reset();
        sys_rst = 1'b1;
        repeat (6) tick();
        sys_rst = 1'b0;
    endtask

    task automatic finish_up();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog timeout actual=running expected=done");
        finish_up();
    end

    initial begin
        @(negedge clk);
        // R4: reset state and reset held long with heartbeat activity
        repeat (3) tick();
        check(wdt_expire == 1'b0, "R4 reset state", int'(wdt_expire), 0);
        acc = 0;
        for (int i = 0; i < 8; i++) begin
            watch(7);
            acc += hits;
            hb_in = ~hb_in;
        end
        check(acc == 0, "R4 held in long reset", acc, 0);

        // R1 / R6: long startup expiry, single pulse, then silence
        do_reset();
        expect_pulse(L, "R1 startup expiry cycle");
        expect_quiet(3 * L, "R6 no further pulse");

        // R2: first change selects the short window
        do_reset();
        expect_quiet(5, "R2 before change");
        hb_in = ~hb_in;
        expect_pulse(D, "R2 short expiry after first change");

        // R3: alternating rising and falling changes keep servicing
        do_reset();
        hb_in = ~hb_in;
        acc = 0;
        for (int i = 0; i < 6; i++) begin
            watch(10);
            acc += hits;
            hb_in = ~hb_in;
        end
        check(acc == 0, "R3 both directions service", acc, 0);
        expect_pulse(D, "R3 expiry after last change");

        // R7: short glitch in startup does not switch mode
        do_reset();
        watch(5);
        hb_in = ~hb_in;
        watch(F - 1);
        hb_in = ~hb_in;
        expect_pulse(L - 5 - (F - 1), "R7 startup glitch ignored");

        // R7: short glitch in normal mode does not service
        do_reset();
        hb_in = ~hb_in;
        watch(10);
        hb_in = ~hb_in;
        watch(F - 1);
        hb_in = ~hb_in;
        expect_pulse(D - 10 - (F - 1), "R7 normal glitch ignored");

        // R7: a level held exactly STABLE cycles is accepted
        do_reset();
        watch(5);
        hb_in = ~hb_in;
        watch(F);
        hb_in = ~hb_in;
        expect_pulse(D, "R7 boundary level accepted");

        // R8: disabled watchdog stays quiet and ignores changes
        sys_rst = 1'b1;
        wd_en = 1'b0;
        repeat (6) tick();
        sys_rst = 1'b0;
        watch(L);
        acc = hits;
        hb_in = ~hb_in;
        watch(2 * L);
        acc += hits;
        check(acc == 0, "R8 disabled no expiry", acc, 0);
        wd_en = 1'b1;
        expect_pulse(L, "R8 enable starts startup window");

        // R5: after a normal-mode expiry, reset restores the long window
        do_reset();
        hb_in = ~hb_in;
        expect_pulse(D, "R5 normal expiry");
        expect_quiet(20, "R6 silent after normal expiry");
        do_reset();
        expect_pulse(L, "R5 long window after reset");

        // R2 sweep: first change at every cycle of the startup window
        acc = 0;
        for (int t0 = 0; t0 <= 30; t0++) begin
            do_reset();
            watch(t0);
            if (hits != 0) acc++;
            hb_in = ~hb_in;
            watch(D);
            if (!(first_hit == D && hits == 1)) begin
                acc++;
                $display("FAIL R2 sweep t0=%0d actual=%0d expected=%0d", t0, first_hit, D);
            end
        end
        checks++;
        if (acc != 0) errors++;

        finish_up();
    end
endmodule